// File: doc/BRIEF.md
# Serial-Port Bit-Clock and Frame-Pulse Generator

This block produces the bit clock and the frame-synchronisation pulse for a synchronous serial port, both derived from the system clock. The bit clock comes from a programmable divider. The frame pulse is counted in bit-clock cycles, with a programmable period and a programmable active width. Three enables are staged so that software brings the port up in order. `gen_en` starts the divider. `frm_en` starts frame pulses. `tx_en` releases the transmitter.

The block keeps track of why the divider is stopped. After a device reset, with `gen_en` never yet set, the bit clock free-runs at half the system clock. Once software has enabled the divider and then cleared it again, the bit clock is parked low. Releasing the transmitter produces a one-cycle ready pulse. Other logic can use this pulse to start loading transmit data.

Top module: `srg_fsync_top`

## Requirements
- R1: After `rst_n` is released and while `gen_en` has not yet been 1, `bit_clk` inverts on every system clock edge, and `frm_sync`, `tx_ready` and `tx_active` are 0.
- R2: With `gen_en`=1 the period of `bit_clk` is D+1 system cycles, where D = `clk_div` (a `clk_div` of 0 is treated as 1). It is high for ceil((D+1)/2) of those cycles. Its first rising edge is at the edge that first samples `gen_en`=1.
- R3: Once `gen_en` has been seen at 1, any later cycle with `gen_en`=0 holds `bit_clk` low. This lasts until the next `rst_n` assertion.
- R4: If `gen_en` or `frm_en` is 0 at a clock edge, `frm_sync` is 0 after that edge.
- R5: The edge that first samples `gen_en`=`frm_en`=1 loads the frame counters. `frm_sync` then rises at the (`frm_period`+1)-th rising edge of `bit_clk` after that edge, and in the same system cycle as that edge.
- R6: `frm_sync` stays high for `frm_width`+1 bit-clock cycles. Successive rising edges of `frm_sync` are `frm_period`+1 bit-clock cycles apart.
- R7: When `frm_width` >= `frm_period`, the start of a new frame takes priority over the end of a pulse, so `frm_sync` stays high once it has risen.
- R8: Clearing `frm_en` while a pulse is high drops `frm_sync` at the next edge. Setting `frm_en` again restarts the R5 count from the beginning.
- R9: A 0-to-1 change of `tx_en` gives `tx_ready`=1 for exactly one system cycle after the next edge. `tx_active` follows `tx_en` with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low device reset, asynchronous |
| gen_en | input | 1 | Divider enable (0 = divider in reset) |
| frm_en | input | 1 | Frame-pulse enable (0 = frame logic in reset) |
| tx_en | input | 1 | Transmitter enable (0 = transmitter in reset) |
| clk_div | input | DIV_W | Divide-down value D |
| frm_period | input | PER_W | Frame period minus one, in bit-clock cycles |
| frm_width | input | WID_W | Pulse width minus one, in bit-clock cycles |
| bit_clk | output | 1 | Generated bit clock |
| frm_sync | output | 1 | Generated frame pulse |
| tx_ready | output | 1 | One-cycle pulse when the transmitter is released |
| tx_active | output | 1 | Transmitter enabled |

## Verification
One bit-clock tick can both end a pulse, because the width count has run out, and start a new frame, because the period count has run out. The bench provokes this by programming a width equal to the period. It then judges R7 by watching that `frm_sync` never falls over many frames. A second collision is clearing `frm_en` in the middle of a pulse. There the reset must win over the running width count at the very next edge, and the re-enabled count must start again at `frm_period`+1.

// File: rtl/srg_pkg.sv
package srg_pkg;
    localparam int unsigned DEF_DIV_W = 8;
    localparam int unsigned DEF_PER_W = 12;
    localparam int unsigned DEF_WID_W = 8;
endpackage

// File: rtl/srg_clkdiv.sv
module srg_clkdiv #(
    parameter int unsigned DIV_W = srg_pkg::DEF_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic [DIV_W-1:0] clk_div,
    output logic             bit_clk,
    output logic             rise_nxt,
    output logic             sw_mode
);
    localparam int unsigned HW = DIV_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             clk;
        logic             run;
        logic             swm;
    } div_st_t;

    div_st_t          st_d, st_q;
    logic [DIV_W-1:0] div_eff;
    logic [HW-1:0]    hi_len;
    logic             wrap;

    always_comb begin
        div_eff = (clk_div == '0) ? DIV_W'(1) : clk_div;
        hi_len  = ({1'b0, div_eff} + HW'(2)) >> 1;
        wrap    = !st_q.run || (st_q.cnt >= div_eff);
        st_d    = st_q;
        if (gen_en) begin
            st_d.swm = 1'b1;
            st_d.run = 1'b1;
            st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
            st_d.clk = ({1'b0, st_d.cnt} < hi_len);
        end else begin
            st_d.run = 1'b0;
            st_d.cnt = '0;
            st_d.clk = st_q.swm ? 1'b0 : ~st_q.clk;
        end
        rise_nxt = gen_en && (st_d.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_clk = st_q.clk;
    assign sw_mode = st_q.swm;
endmodule

// File: rtl/srg_framer.sv
module srg_framer #(
    parameter int unsigned PER_W = srg_pkg::DEF_PER_W,
    parameter int unsigned WID_W = srg_pkg::DEF_WID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic [PER_W-1:0] frm_period,
    input  logic [WID_W-1:0] frm_width,
    output logic             frm_sync
);
    typedef struct packed {
        logic [PER_W-1:0] fcnt;
        logic [WID_W-1:0] wcnt;
        logic             pulse;
        logic             run;
    } frm_st_t;

    frm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d = '0;
        end else if (!st_q.run) begin
            st_d.run   = 1'b1;
            st_d.fcnt  = frm_period;
            st_d.pulse = 1'b0;
        end else if (tick) begin
            if (st_q.pulse) begin
                if (st_q.wcnt == '0) st_d.pulse = 1'b0;
                else                 st_d.wcnt  = st_q.wcnt - 1'b1;
            end
            // a new frame start overrides a pulse end on the same tick
            if (st_q.fcnt == '0) begin
                st_d.fcnt  = frm_period;
                st_d.wcnt  = frm_width;
                st_d.pulse = 1'b1;
            end else begin
                st_d.fcnt = st_q.fcnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frm_sync = st_q.pulse;
endmodule

// File: rtl/srg_fsync_top.sv
module srg_fsync_top #(
    parameter int unsigned DIV_W = srg_pkg::DEF_DIV_W,
    parameter int unsigned PER_W = srg_pkg::DEF_PER_W,
    parameter int unsigned WID_W = srg_pkg::DEF_WID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic             frm_en,
    input  logic             tx_en,
    input  logic [DIV_W-1:0] clk_div,
    input  logic [PER_W-1:0] frm_period,
    input  logic [WID_W-1:0] frm_width,
    output logic             bit_clk,
    output logic             frm_sync,
    output logic             tx_ready,
    output logic             tx_active
);
    typedef struct packed {
        logic active;
        logic ready;
    } tx_st_t;

    tx_st_t tx_d, tx_q;
    logic   rise_nxt;
    logic   sw_mode;

    srg_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .gen_en   (gen_en),
        .clk_div  (clk_div),
        .bit_clk  (bit_clk),
        .rise_nxt (rise_nxt),
        .sw_mode  (sw_mode)
    );

    srg_framer #(.PER_W(PER_W), .WID_W(WID_W)) u_frm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (gen_en && frm_en),
        .tick       (rise_nxt),
        .frm_period (frm_period),
        .frm_width  (frm_width),
        .frm_sync   (frm_sync)
    );

    always_comb begin
        tx_d.active = tx_en;
        tx_d.ready  = tx_en && !tx_q.active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign tx_ready  = tx_q.ready;
    assign tx_active = tx_q.active;
endmodule

// File: rtl/srg_fsync_chk.sv
module srg_fsync_chk (
    input logic clk,
    input logic rst_n,
    input logic gen_en,
    input logic frm_en,
    input logic tx_en,
    input logic bit_clk,
    input logic frm_sync,
    input logic tx_ready,
    input logic tx_active,
    input logic sw_mode
);
    p_boot_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_en && !sw_mode) |=> (bit_clk != $past(bit_clk)));

    p_sw_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_en && sw_mode) |=> !bit_clk);

    p_fsync_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_en || !frm_en) |=> !frm_sync);

    p_ready_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !tx_active) |=> tx_ready);

    p_ready_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> !tx_ready);

    p_ready_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> tx_active);
endmodule

bind srg_fsync_top srg_fsync_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen_en    (gen_en),
    .frm_en    (frm_en),
    .tx_en     (tx_en),
    .bit_clk   (bit_clk),
    .frm_sync  (frm_sync),
    .tx_ready  (tx_ready),
    .tx_active (tx_active),
    .sw_mode   (sw_mode)
);

// File: tb/srg_fsync_top_tb_top.sv
module srg_fsync_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_en = 1'b0, frm_en = 1'b0, tx_en = 1'b0;
    logic [7:0]  clk_div = '0;
    logic [11:0] frm_period = '0;
    logic [7:0]  frm_width = '0;
    logic        bit_clk, frm_sync, tx_ready, tx_active;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    srg_fsync_top dut_i (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .frm_en(frm_en), .tx_en(tx_en),
        .clk_div(clk_div), .frm_period(frm_period), .frm_width(frm_width),
        .bit_clk(bit_clk), .frm_sync(frm_sync), .tx_ready(tx_ready), .tx_active(tx_active)
    );

    // div, period, width | exp clk period, exp high, exp first, exp width, exp frame
    localparam int VEC [5][8] = '{
        '{1, 3, 0, 2, 1, 4, 1, 4},
        '{2, 4, 1, 3, 2, 5, 2, 5},
        '{4, 2, 1, 5, 3, 3, 2, 3},
        '{0, 5, 2, 2, 1, 6, 3, 6},
        '{3, 1, 0, 4, 2, 2, 1, 2}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // returns bit_clk period and high time in system cycles
    task automatic meas_clk(output int per, output int hi);
        logic prev;
        int   guard;
        per = -1; hi = -1; guard = 0;
        prev = bit_clk;
        while (guard < 100) begin
            @(negedge clk); guard++;
            if (bit_clk && !prev) break;
            prev = bit_clk;
        end
        if (guard >= 100) return;
        hi = 1; per = 0; prev = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            per++;
            if (bit_clk && !prev) return;
            if (bit_clk) hi++;
            prev = bit_clk;
        end
        per = -1;
    endtask

    // enables frames, counts bit_clk rises to first pulse, pulse width, frame
    task automatic meas_frame(output int first, output int wid, output int frame);
        logic prev;
        logic fell;
        int   m;
        first = -1; wid = -1; frame = -1;
        frm_en = 1'b1;
        @(negedge clk);
        prev = bit_clk;
        m = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (bit_clk && !prev) m++;
            prev = bit_clk;
            if (frm_sync) begin first = m; break; end
        end
        if (first < 0) return;
        m = 0; fell = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (bit_clk && !prev) m++;
            prev = bit_clk;
            if (!frm_sync && !fell) begin fell = 1'b1; wid = m; end
            if (frm_sync && fell) begin frame = m; break; end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int per, hi, first, wid, frame, cnt;
        logic prev;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 frm_sync after reset", int'(frm_sync), 0);
        chk("R1 tx_ready after reset", int'(tx_ready), 0);
        chk("R1 tx_active after reset", int'(tx_active), 0);
        cnt = 0;
        for (int i = 0; i < 6; i++) begin
            prev = bit_clk;
            @(negedge clk);
            if (bit_clk != prev) cnt++;
        end
        chk("R1 boot toggles in 6 cycles", cnt, 6);

        // enable then clear: software reset parks bit_clk low
        clk_div = 8'd1;
        gen_en = 1'b1;
        repeat (6) @(negedge clk);
        gen_en = 1'b0;
        @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 12; i++) begin
            if (bit_clk || frm_sync) cnt++;
            @(negedge clk);
        end
        chk("R3 bit_clk held low after software clear", cnt, 0);

        // vector table
        for (int v = 0; v < 5; v++) begin
            clk_div    = 8'(VEC[v][0]);
            frm_period = 12'(VEC[v][1]);
            frm_width  = 8'(VEC[v][2]);
            @(negedge clk);
            gen_en = 1'b1;
            @(negedge clk);
            chk("R2 first rise on enabling edge", int'(bit_clk), 1);
            meas_clk(per, hi);
            chk("R2 bit_clk period", per, VEC[v][3]);
            chk("R2 bit_clk high time", hi, VEC[v][4]);
            meas_frame(first, wid, frame);
            chk("R5 rises to first frm_sync", first, VEC[v][5]);
            chk("R6 frm_sync width", wid, VEC[v][6]);
            chk("R6 frame period", frame, VEC[v][7]);
            gen_en = 1'b0;
            @(negedge clk);
            chk("R4 frm_sync low after gen_en clear", int'(frm_sync), 0);
            frm_en = 1'b0;
            @(negedge clk);
        end

        // R8: clear mid-pulse, re-enable restarts the count
        clk_div = 8'd1; frm_period = 12'd5; frm_width = 8'd3;
        gen_en = 1'b1;
        @(negedge clk);
        meas_frame(first, wid, frame);
        chk("R8 setup first pulse", first, 6);
        @(negedge clk);
        chk("R8 pulse high before clear", int'(frm_sync), 1);
        frm_en = 1'b0;
        @(negedge clk);
        chk("R8 frm_sync drops after clear", int'(frm_sync), 0);
        repeat (3) @(negedge clk);
        meas_frame(first, wid, frame);
        chk("R8 re-enable restarts count", first, 6);
        frm_en = 1'b0;
        @(negedge clk);

        // R7: width equals period -> pulse never falls
        frm_period = 12'd2; frm_width = 8'd2;
        @(negedge clk);
        meas_frame(first, wid, frame);
        chk("R7 frm_sync stays high (no fall seen)", wid, -1);
        frm_en = 1'b0; gen_en = 1'b0;
        @(negedge clk);
        chk("R4 frm_sync low after both cleared", int'(frm_sync), 0);

        // R9: transmitter release
        tx_en = 1'b1;
        @(negedge clk);
        chk("R9 tx_ready pulse", int'(tx_ready), 1);
        chk("R9 tx_active follows", int'(tx_active), 1);
        @(negedge clk);
        chk("R9 tx_ready single cycle", int'(tx_ready), 0);
        tx_en = 1'b0;
        @(negedge clk);
        chk("R9 tx_active clears", int'(tx_active), 0);
        chk("R9 no ready on fall", int'(tx_ready), 0);

        summary();
        $finish;
    end
endmodule